// File: doc/BRIEF.md
# APB Register File with Access-Error Response

This block is the slave side of an APB bus for a small set of control registers. It decodes byte addresses into four word registers: two read-write words, one read-only word that mirrors a hardware status input, and one write-only command word. Every transfer completes with zero wait states. Bus signals are separate flat ports.

Two elaboration-time options add an error response on `pslverr`. One flags accesses to addresses that hold no register. The other flags reads of the write-only word and writes to the read-only word. A third option picks the bus flavour. The APB3 flavour never raises `pslverr` and ignores `pstrb`, even when the error options are set. The ports stay the same in every build, so one netlist shape fits both flavours.

Top module: `apb_regfile_err`

## Requirements
- R1: `paddr` is a byte address. Word offset 0x0 is the control word (read-write), 0x4 is the scratch word (read-write), 0x8 is the status word (read-only, reads `hw_status`) and 0xC is the command word (write-only). An address maps only when all bits above bit 3 are zero. Bits 1:0 take no part in the selection.
- R2: `pready` is high in every access-phase cycle (`psel` and `penable` both high) and low in every other cycle.
- R3: In the APB4 flavour, a write to a read-write word updates only the byte lanes whose `pstrb` bit is 1. Lane k is bits 8k+7:8k.
- R4: A read access returns the selected word on `prdata` in the access-phase cycle. Reading the command word without an error returns zero. `prdata` is zero outside read access phases.
- R5: With the bad-address option on (APB4), an access to an unmapped address completes with `pslverr` high.
- R6: With the bad-direction option on (APB4), a read of the command word completes with `pslverr` high.
- R7: With the bad-direction option on (APB4), a write to the status word completes with `pslverr` high.
- R8: A write that completes with `pslverr` high changes no register, and does not pulse `cmd_strobe`. A read that completes with `pslverr` high returns zero on `prdata`.
- R9: `pslverr` is low in every cycle that is not an access-phase cycle.
- R10: In the APB3 flavour, `pslverr` stays low and `pstrb` is ignored, so every write to a read-write word replaces the whole word.
- R11: An accepted write to the command word loads `cmd_q` at the end of the access phase. `cmd_strobe` is then high for exactly the next cycle.
- R12: With an error option off, the accesses it would flag complete without error. Writes to the status word or to unmapped addresses change nothing, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write enables (APB4 only) |
| pprot | input | 3 | Protection type, unused |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Transfer error |
| hw_status | input | DATA_W | Value shown by the status word |
| ctrl_q | output | DATA_W | Control word contents |
| cmd_q | output | DATA_W | Last accepted command word |
| cmd_strobe | output | 1 | One-cycle pulse after a command write |

## Verification
`pready`, `pslverr` and `prdata` are combinational in the access-phase cycle, so the bench compares them in that same cycle. Register contents, `ctrl_q` and `cmd_q` change on the edge that ends the access phase, and `cmd_strobe` is high during the cycle after that edge. The bench drives inputs just after each rising edge and samples on the falling edge. A behavioural model updates at the rising edges and is compared against three builds (APB4 with both options, APB3 with both options, and APB4 with both options off) in every cycle.

// File: rtl/apb_regfile_err.sv
module apb_regfile_err #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter bit APB4         = 1'b1,
  parameter bit ERR_BAD_ADDR = 1'b1,
  parameter bit ERR_BAD_DIR  = 1'b1
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [2:0]          pprot,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  output logic                pslverr,
  input  logic [DATA_W-1:0]   hw_status,
  output logic [DATA_W-1:0]   ctrl_q,
  output logic [DATA_W-1:0]   cmd_q,
  output logic                cmd_strobe
);
  localparam int LANES = DATA_W / 8;

  logic              access, mapped, is_ro, is_wo, bad_addr, bad_dir, err, wr_ok;
  logic [1:0]        idx;
  logic [DATA_W-1:0] scratch_q, lane_mask, rd_word;

  assign access   = psel & penable;
  assign idx      = paddr[3:2];
  assign mapped   = (paddr[ADDR_W-1:4] == '0);
  assign is_ro    = (idx == 2'd2);
  assign is_wo    = (idx == 2'd3);
  assign bad_addr = ERR_BAD_ADDR & ~mapped;
  assign bad_dir  = ERR_BAD_DIR & mapped & ((pwrite & is_ro) | (~pwrite & is_wo));
  assign err      = APB4 & access & (bad_addr | bad_dir);
  assign wr_ok    = access & pwrite & mapped & ~err;

  assign pready  = access;
  assign pslverr = err;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = (APB4 ? pstrb[k] : 1'b1) ? 8'hFF : 8'h00;
  end

  always_comb begin
    case (idx)
      2'd0:    rd_word = ctrl_q;
      2'd1:    rd_word = scratch_q;
      2'd2:    rd_word = hw_status;
      default: rd_word = '0;
    endcase
  end

  assign prdata = (access & ~pwrite & mapped & ~err) ? rd_word : '0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q     <= '0;
      scratch_q  <= '0;
      cmd_q      <= '0;
      cmd_strobe <= 1'b0;
    end else begin
      cmd_strobe <= wr_ok & is_wo;
      if (wr_ok) begin
        case (idx)
          2'd0:    ctrl_q    <= (ctrl_q & ~lane_mask) | (pwdata & lane_mask);
          2'd1:    scratch_q <= (scratch_q & ~lane_mask) | (pwdata & lane_mask);
          2'd3:    cmd_q     <= pwdata;
          default: ;
        endcase
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^{pprot, paddr[1:0], pstrb};
endmodule

module apb_regfile_err_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter bit APB4   = 1'b1
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cmd_q,
  input logic              cmd_strobe
);
  AST_READY_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable) |-> pready); // R2
  AST_READY_ONLY_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (psel && penable)); // R2
  AST_ERR_ONLY_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (psel && penable && pready)); // R9
  AST_ERR_READ_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && !pwrite) |-> (prdata == '0)); // R8
  AST_ERR_WRITE_KEEPS_CTRL: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && pwrite) |=> $stable(ctrl_q)); // R8
  AST_ERR_WRITE_KEEPS_CMD: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && pwrite) |=> ($stable(cmd_q) && !cmd_strobe)); // R8
  AST_STROBE_AFTER_CMD: assert property (@(posedge pclk) disable iff (!presetn)
    cmd_strobe |-> $past(psel && penable && pwrite && !pslverr
                         && paddr[3:2] == 2'd3 && paddr[ADDR_W-1:4] == '0)); // R11
  AST_STROBE_SINGLE: assert property (@(posedge pclk) disable iff (!presetn)
    cmd_strobe |=> !cmd_strobe); // R11

  always @(negedge pclk)
    if (!APB4) AST_APB3_NO_ERR: assert (!pslverr); // R10
endmodule

bind apb_regfile_err apb_regfile_err_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .APB4(APB4)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .ctrl_q(ctrl_q), .cmd_q(cmd_q), .cmd_strobe(cmd_strobe));

// File: tb/tb_apb_regfile_err.sv
module tb_apb_regfile_err;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NV = 3;

  logic          pclk = 1'b0, presetn = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0, hw_status = 32'hC0DE_1234;
  logic [3:0]    pstrb = 4'hF;
  logic [2:0]    pprot = 3'd0;

  logic [DW-1:0] o_rdata [NV];
  logic          o_ready [NV];
  logic          o_err   [NV];
  logic [DW-1:0] o_ctrl  [NV];
  logic [DW-1:0] o_cmd   [NV];
  logic          o_stb   [NV];

  bit            v_apb4 [NV] = '{1'b1, 1'b0, 1'b1};
  bit            v_ea   [NV] = '{1'b1, 1'b1, 1'b0};
  bit            v_ed   [NV] = '{1'b1, 1'b1, 1'b0};
  logic [DW-1:0] m_ctrl [NV], m_scr [NV], m_cmd [NV];
  logic          m_stb  [NV];

  int    checks = 0, failures = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_regfile_err #(.ADDR_W(AW), .DATA_W(DW), .APB4(1'b1), .ERR_BAD_ADDR(1'b1), .ERR_BAD_DIR(1'b1)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .prdata(o_rdata[0]), .pready(o_ready[0]),
    .pslverr(o_err[0]), .hw_status(hw_status), .ctrl_q(o_ctrl[0]), .cmd_q(o_cmd[0]), .cmd_strobe(o_stb[0]));
  apb_regfile_err #(.ADDR_W(AW), .DATA_W(DW), .APB4(1'b0), .ERR_BAD_ADDR(1'b1), .ERR_BAD_DIR(1'b1)) dut_apb3 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .prdata(o_rdata[1]), .pready(o_ready[1]),
    .pslverr(o_err[1]), .hw_status(hw_status), .ctrl_q(o_ctrl[1]), .cmd_q(o_cmd[1]), .cmd_strobe(o_stb[1]));
  apb_regfile_err #(.ADDR_W(AW), .DATA_W(DW), .APB4(1'b1), .ERR_BAD_ADDR(1'b0), .ERR_BAD_DIR(1'b0)) dut_noerr (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .prdata(o_rdata[2]), .pready(o_ready[2]),
    .pslverr(o_err[2]), .hw_status(hw_status), .ctrl_q(o_ctrl[2]), .cmd_q(o_cmd[2]), .cmd_strobe(o_stb[2]));

  function automatic bit exp_err(int v);
    int  slot = int'(paddr[3:2]);
    bit  inmap = (paddr >> 4) == 0;
    if (!(psel && penable) || !v_apb4[v]) return 1'b0;
    if (v_ea[v] && !inmap) return 1'b1;
    if (v_ed[v] && inmap && ((pwrite && slot == 2) || (!pwrite && slot == 3))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] exp_rdata(int v);
    int slot = int'(paddr[3:2]);
    if (!(psel && penable) || pwrite || exp_err(v) || (paddr >> 4) != 0) return '0;
    case (slot)
      0: return m_ctrl[v];
      1: return m_scr[v];
      2: return hw_status;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, int v);
    logic [DW-1:0] r = old;
    for (int k = 0; k < 4; k++)
      if (!v_apb4[v] || pstrb[k]) r[8*k +: 8] = pwdata[8*k +: 8];
    return r;
  endfunction

  always @(posedge pclk) begin
    for (int v = 0; v < NV; v++) begin
      if (!presetn) begin
        m_ctrl[v] = '0; m_scr[v] = '0; m_cmd[v] = '0; m_stb[v] = 1'b0;
      end else begin
        m_stb[v] = 1'b0;
        if (psel && penable && pwrite && !exp_err(v) && (paddr >> 4) == 0) begin
          case (int'(paddr[3:2]))
            0: m_ctrl[v] = merge(m_ctrl[v], v);
            1: m_scr[v]  = merge(m_scr[v], v);
            3: begin m_cmd[v] = pwdata; m_stb[v] = 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge pclk) begin
    if (presetn !== 1'bx && m_ctrl[0] !== 'x) begin
      for (int v = 0; v < NV; v++) begin
        string tag = $sformatf("%s[v%0d]", cur_req, v);
        check(o_ready[v] === (psel && penable), "R2", "pready", DW'(o_ready[v]), DW'(psel && penable));
        check(o_err[v] === exp_err(v), (psel && penable) ? tag : "R9", "pslverr", DW'(o_err[v]), DW'(exp_err(v)));
        check(o_rdata[v] === exp_rdata(v), tag, "prdata", o_rdata[v], exp_rdata(v));
        check(o_ctrl[v] === m_ctrl[v], tag, "ctrl_q", o_ctrl[v], m_ctrl[v]);
        check(o_cmd[v] === m_cmd[v], tag, "cmd_q", o_cmd[v], m_cmd[v]);
        check(o_stb[v] === m_stb[v], "R11", "cmd_strobe", DW'(o_stb[v]), DW'(m_stb[v]));
      end
    end
  end

  task automatic xfer(string req, bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] s);
    cur_req = req;
    @(posedge pclk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwdata = '0; pstrb = 4'h0;
    @(posedge pclk); #1;
  endtask

  initial begin
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;
    xfer("R1", 1'b1, 12'h000, 32'h1122_3344, 4'hF);
    xfer("R1", 1'b0, 12'h000, '0, 4'h0);
    xfer("R3", 1'b1, 12'h004, 32'hAABB_CCDD, 4'b0101);
    xfer("R3", 1'b0, 12'h004, '0, 4'h0);
    xfer("R10", 1'b1, 12'h000, 32'h5566_7788, 4'b0010);
    xfer("R1", 1'b0, 12'h006, '0, 4'h0);
    xfer("R4", 1'b0, 12'h008, '0, 4'h0);
    hw_status = 32'h0BAD_F00D;
    xfer("R4", 1'b0, 12'h00B, '0, 4'h0);
    xfer("R11", 1'b1, 12'h00C, 32'hDEAD_BEEF, 4'hF);
    xfer("R6", 1'b0, 12'h00C, '0, 4'h0);
    xfer("R7", 1'b1, 12'h008, 32'hFFFF_FFFF, 4'hF);
    xfer("R5", 1'b0, 12'h010, '0, 4'h0);
    xfer("R5", 1'b1, 12'h040, 32'h1234_5678, 4'hF);
    xfer("R8", 1'b1, 12'h400, 32'h0F0F_0F0F, 4'hF);
    xfer("R8", 1'b0, 12'h000, '0, 4'h0);
    xfer("R12", 1'b1, 12'h800, 32'h9999_9999, 4'hF);
    xfer("R12", 1'b0, 12'hFFC, '0, 4'h0);
    xfer("R11", 1'b1, 12'h00C, 32'h0000_0001, 4'h0);
    xfer("R3", 1'b1, 12'h004, 32'h0102_0304, 4'b1000);
    xfer("R3", 1'b0, 12'h004, '0, 4'h0);
    repeat (3) @(posedge pclk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge pclk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule